// File: doc/BRIEF.md
# Multi-Channel ADC Event Packer with Fill-Level Interrupt

This block collects 14-bit digitised samples from four ADC lanes, one lane per front-end board. Each sample is checked against a programmable acceptance window, which rejects pedestal values and overflowed conversions. A sample that passes is combined with its board number, its channel number, an energy/time tag and the low bits of the running event number into a 32-bit word. That word is stored in an internal FIFO. A sample that fails the window check is discarded.

All lanes share one channel index, one energy/time tag and one event counter, all driven by the readout sequencer. These values are captured together with each sample. When several lanes deliver a sample in the same cycle, each sample waits in a one-entry holding register on its own lane. A round-robin arbiter then moves one word per cycle into the FIFO.

The FIFO fill count is an output. A level-sensitive interrupt stays high while the fill count is above a programmable threshold, so a host can drain the FIFO in bursts. A sticky overflow flag records any word lost to a full FIFO or to a busy holding register. A host write clears the flag.

Top module: `adc_event_packer`

## Requirements
- R1: Each stored word is laid out as bits [31:24] = event number bits [7:0], [23:22] = lane (board) index 0..3, [21] = energy/time tag, [20:14] = channel index, [13:0] = sample.
- R2: A sample is accepted only when lim_lo < sample < lim_hi, with both comparisons strict. A rejected sample leaves the fill count and the overflow flag unchanged.
- R3: When lanes have words waiting, exactly one word enters the FIFO per cycle. The search starts at the lane after the most recently granted lane. After reset it starts at lane 0.
- R4: fill_count gives the number of stored words, from 0 to FIFO_DEPTH. An accepted sample strobed before clock edge k is counted after edge k+1.
- R5: A word granted while the FIFO holds FIFO_DEPTH words is dropped, the fill count stays at FIFO_DEPTH, and ovf_flag becomes 1.
- R6: ovf_flag stays 1 until a cycle with ovf_clr high and no new loss in the same cycle. After that cycle it reads 0.
- R7: irq is 1 exactly when fill_count > irq_thresh, and it returns to 0 in the same cycle the count falls to the threshold.
- R8: rd_data always shows the oldest stored word. Asserting rd_pop removes it. rd_pop while the FIFO is empty has no effect.
- R9: An accepted sample that arrives on a lane whose holding register is full, and is not granted in that cycle, is dropped and sets ovf_flag.
- R10: After reset, fill_count = 0, irq = 0 and ovf_flag = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 4 | Per-lane sample strobe |
| smp_data | input | 56 | Per-lane 14-bit samples, lane i at bits [14i+13:14i] |
| chan_idx | input | 7 | Channel index from sequencer |
| et_tag | input | 1 | Energy (0) / time (1) tag |
| evt_num | input | 16 | Event counter |
| lim_lo | input | 14 | Lower acceptance limit (exclusive) |
| lim_hi | input | 14 | Upper acceptance limit (exclusive) |
| irq_thresh | input | 5 | Interrupt fill threshold |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_pop | input | 1 | Remove the oldest word |
| rd_data | output | 32 | Oldest stored word |
| fill_count | output | 5 | Number of stored words |
| irq | output | 1 | Fill-above-threshold interrupt |
| ovf_flag | output | 1 | Sticky loss flag |

## Verification
Sample values are swept across and around both window edges on every lane: zero, each limit, each limit ±1, mid-range and full-scale. This separates strict comparisons from inclusive ones and also checks the lane and field placement of each word. Simultaneous strobes on different subsets of lanes show whether grants rotate from the last winner or follow a fixed priority. Back-to-back strobes on a lane with a waiting word show whether that word is overwritten or the new sample is dropped. A fill to capacity and a full drain, one word at a time, check the interrupt at every count around the threshold, the overflow flag and its clear, and pops on an empty FIFO.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int SMP_W   = 14;
  localparam int CHN_W   = 7;
  localparam int BRD_W   = 2;
  localparam int EVTF_W  = 8;
  localparam int WORD_W  = 32;

  function automatic logic in_window(input logic [SMP_W-1:0] s,
                                     input logic [SMP_W-1:0] lo,
                                     input logic [SMP_W-1:0] hi);
    return (s > lo) && (s < hi);
  endfunction

  function automatic logic [WORD_W-1:0] make_word(input logic [EVTF_W-1:0] evt,
                                                  input logic [BRD_W-1:0]  brd,
                                                  input logic              tag,
                                                  input logic [CHN_W-1:0]  chn,
                                                  input logic [SMP_W-1:0]  s);
    return {evt, brd, tag, chn, s};
  endfunction
endpackage

// File: rtl/pkt_lane.sv
module pkt_lane
  import pkt_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [SMP_W-1:0]  smp,
  input  logic [CHN_W-1:0]  chn,
  input  logic              tag,
  input  logic [EVTF_W-1:0] evt,
  input  logic [SMP_W-1:0]  lo,
  input  logic [SMP_W-1:0]  hi,
  input  logic              grant,
  output logic              pending,
  output logic [WORD_W-1:0] word,
  output logic              busy_drop
);
  logic accept;
  logic load;

  assign accept    = stb && in_window(smp, lo, hi);
  assign load      = accept && (!pending || grant);
  assign busy_drop = accept && pending && !grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      word    <= '0;
    end else if (load) begin
      pending <= 1'b1;
      word    <= make_word(evt, BRD_W'(LANE), tag, chn, smp);
    end else if (grant) begin
      pending <= 1'b0;
    end
  end

  // R2: a rejected sample never fills an empty holding register
  a_r2_reject_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !in_window(smp, lo, hi) && !pending) |=> !pending);
  // R9: a busy lane keeps its waiting word
  a_r9_busy_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    busy_drop |=> (pending && $stable(word)));
endmodule

// File: rtl/pkt_arbiter.sv
module pkt_arbiter #(
  parameter int N     = 4,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [IW-1:0] gnt_idx,
  output logic         any_grant
);
  logic [IW-1:0] last;

  always_comb begin
    logic found;
    found   = 1'b0;
    grant   = '0;
    gnt_idx = '0;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = int'(last) + off;
      if (cand >= N) cand = cand - N;
      if (!found && req[cand]) begin
        found       = 1'b1;
        grant[cand] = 1'b1;
        gnt_idx     = IW'(cand);
      end
    end
    any_grant = found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last <= IW'(N - 1);
    else if (any_grant) last <= gnt_idx;
  end

  // R3: at most one grant, only to a requester
  a_r3_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
  // R3: a pending request is never left without a grant
  a_r3_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> any_grant);
endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int W      = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (count != '0);
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R4: the count never exceeds capacity
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R8: popping an empty FIFO without a push leaves it empty
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop && !push) |=> (count == '0));
endmodule

// File: rtl/adc_event_packer.sv
module adc_event_packer
  import pkt_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int EVT_IN_W   = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int IW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         smp_stb,
  input  logic [NUM_CH*SMP_W-1:0]   smp_data,
  input  logic [CHN_W-1:0]          chan_idx,
  input  logic                      et_tag,
  input  logic [EVT_IN_W-1:0]       evt_num,
  input  logic [SMP_W-1:0]          lim_lo,
  input  logic [SMP_W-1:0]          lim_hi,
  input  logic [CNT_W-1:0]          irq_thresh,
  input  logic                      ovf_clr,
  input  logic                      rd_pop,
  output logic [WORD_W-1:0]         rd_data,
  output logic [CNT_W-1:0]          fill_count,
  output logic                      irq,
  output logic                      ovf_flag
);
  logic [NUM_CH-1:0] pend, grant, busy_drop;
  logic [WORD_W-1:0] lane_word [NUM_CH];
  logic [IW-1:0]     gnt_idx;
  logic              any_grant;
  logic              fifo_full;
  logic              full_drop;
  logic              loss;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    pkt_lane #(.LANE(i)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (smp_stb[i]),
      .smp       (smp_data[i*SMP_W +: SMP_W]),
      .chn       (chan_idx),
      .tag       (et_tag),
      .evt       (evt_num[EVTF_W-1:0]),
      .lo        (lim_lo),
      .hi        (lim_hi),
      .grant     (grant[i]),
      .pending   (pend[i]),
      .word      (lane_word[i]),
      .busy_drop (busy_drop[i])
    );
  end

  pkt_arbiter #(.N(NUM_CH)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (pend),
    .grant     (grant),
    .gnt_idx   (gnt_idx),
    .any_grant (any_grant)
  );

  pkt_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (any_grant),
    .din   (lane_word[gnt_idx]),
    .pop   (rd_pop),
    .dout  (rd_data),
    .count (fill_count),
    .full  (fifo_full)
  );

  assign full_drop = any_grant && fifo_full;
  assign loss      = full_drop || (busy_drop != '0);
  assign irq       = fill_count > irq_thresh;

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (loss)     ovf_flag <= 1'b1;
    else if (ovf_clr)  ovf_flag <= 1'b0;
  end

  // R5: a word lost to a full FIFO raises the flag and keeps the count
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    full_drop && !rd_pop |=> ovf_flag && (fill_count == CNT_W'(FIFO_DEPTH)));
  // R6: the flag is sticky without a clear
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R9: a busy-lane drop raises the flag
  a_r9_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_drop != '0) |=> ovf_flag);
  // R7: the interrupt falls with the count dropping to the threshold
  a_r7_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && fill_count <= irq_thresh && $stable(irq_thresh)) |-> !irq);
endmodule

// File: tb/sim_adc_event_packer.sv
module sim_adc_event_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  smp_stb = '0;
  logic [55:0] smp_data = '0;
  logic [6:0]  chan_idx = '0;
  logic        et_tag = 1'b0;
  logic [15:0] evt_num = '0;
  logic [13:0] lim_lo = 14'd100;
  logic [13:0] lim_hi = 14'd200;
  logic [4:0]  irq_thresh = 5'd31;
  logic        ovf_clr = 1'b0;
  logic        rd_pop = 1'b0;
  logic [31:0] rd_data;
  logic [4:0]  fill_count;
  logic        irq;
  logic        ovf_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  adc_event_packer u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
    .chan_idx(chan_idx), .et_tag(et_tag), .evt_num(evt_num),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .irq_thresh(irq_thresh),
    .ovf_clr(ovf_clr), .rd_pop(rd_pop), .rd_data(rd_data),
    .fill_count(fill_count), .irq(irq), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input int evt, input int brd,
                                              input int tag, input int ch, input int s);
    return 32'((evt % 256) * 16777216 + brd * 4194304 + tag * 2097152 + ch * 16384 + s);
  endfunction

  task automatic set_smp(input int lane, input int s);
    smp_data[lane*14 +: 14] = 14'(s);
  endtask

  task automatic pop_one();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  task automatic strobe(input logic [3:0] lanes);
    @(negedge clk) smp_stb = lanes;
    @(negedge clk) smp_stb = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 count", 32'(fill_count), 0);
    chk("R10 irq", 32'(irq), 0);
    chk("R10 ovf", 32'(ovf_flag), 0);

    // R1/R2 window sweep on every lane
    for (int lane = 0; lane < 4; lane++) begin
      for (int k = 0; k < 9; k++) begin
        int vals[9] = '{0, 99, 100, 101, 150, 199, 200, 201, 16383};
        int v;
        bit ok;
        v = vals[k];
        ok = (v > 100) && (v < 200);
        chan_idx = 7'((lane * 23 + k * 11) % 96);
        et_tag   = 1'((lane + k) % 2);
        evt_num  = 16'(lane * 300 + k * 37 + 5);
        set_smp(lane, v);
        strobe(4'(1 << lane));
        chk("R2 accept count", 32'(fill_count), ok ? 1 : 0);
        if (ok) begin
          chk("R1 word layout", rd_data,
              expect_word(lane * 300 + k * 37 + 5, lane, (lane + k) % 2,
                          (lane * 23 + k * 11) % 96, v));
          pop_one();
        end
      end
    end
    chk("R2 no flag", 32'(ovf_flag), 0);

    // R3 round robin: lanes 0 and 2, then all four
    for (int i = 0; i < 4; i++) set_smp(i, 110 + i);
    chan_idx = 7'd5; et_tag = 1'b0; evt_num = 16'd9;
    strobe(4'b0101);
    @(negedge clk);
    chk("R3 two words", 32'(fill_count), 2);
    chk("R3 first lane0", 32'(rd_data[23:22]), 0); pop_one();
    chk("R3 then lane2", 32'(rd_data[23:22]), 2); pop_one();
    strobe(4'b1111);
    repeat (3) @(negedge clk);
    chk("R4 four words", 32'(fill_count), 4);
    for (int j = 0; j < 4; j++) begin
      chk("R3 rotated order", 32'(rd_data[23:22]), 32'((3 + j) % 4));
      chk("R1 sample of lane", 32'(rd_data[13:0]), 32'(110 + (3 + j) % 4));
      pop_one();
    end

    // R9 busy lane: lanes 0,1 strobed two cycles in a row
    set_smp(0, 120); set_smp(1, 121);
    @(negedge clk) smp_stb = 4'b0011;
    @(negedge clk) begin smp_stb = 4'b0011; set_smp(0, 130); set_smp(1, 131); end
    @(negedge clk) smp_stb = '0;
    repeat (3) @(negedge clk);
    chk("R9 three words", 32'(fill_count), 3);
    chk("R9 flag set", 32'(ovf_flag), 1);
    chk("R9 w0", 32'(rd_data[13:0]), 120); pop_one();
    chk("R9 w1", 32'(rd_data[13:0]), 121); pop_one();
    chk("R9 w2", 32'(rd_data[13:0]), 130); pop_one();
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R6 cleared", 32'(ovf_flag), 0);

    // R4/R5/R7 fill to capacity and beyond
    irq_thresh = 5'd5;
    for (int n = 1; n <= 17; n++) begin
      chan_idx = 7'(n);
      set_smp(2, 150);
      strobe(4'b0100);
      chk("R4 fill count", 32'(fill_count), n > 16 ? 16 : n);
      chk("R7 irq on fill", 32'(irq), (n > 5) ? 1 : 0);
      chk("R5 ovf", 32'(ovf_flag), (n > 16) ? 1 : 0);
    end
    for (int n = 16; n >= 1; n--) begin
      chk("R8 oldest first", 32'(rd_data[20:14]), 32'(17 - n));
      pop_one();
      chk("R7 irq on drain", 32'(irq), ((n - 1) > 5) ? 1 : 0);
    end
    pop_one();
    chk("R8 empty pop", 32'(fill_count), 0);
    chk("R6 still set", 32'(ovf_flag), 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R6 clear", 32'(ovf_flag), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule